// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter with Selectable Justification

This block turns a stream of stereo sample pairs into a single serial data line, framed by a bit clock and a left/right select clock. Each channel has a slot of a fixed number of bit clocks. A sample of run-time width sits in that slot in one of three placements. In the standard placement the MSB comes one bit after the slot edge. In the left-justified placement the MSB comes at the slot edge. In the right-justified placement the LSB is the last bit of the slot. Bit positions that carry no sample bit are driven as zero.

The block can own the link clocks or follow them. As clock owner it divides the system clock into the bit clock and counts bit clocks to form the left/right clock, which therefore runs at the sample rate. As follower it synchronises an external bit clock and left/right clock into the system clock domain. It moves its data on the falling bit-clock edge and locks its slot counter to the external left/right transitions. A valid/ready handshake fills a one-pair holding register. That register is moved into the active pair at the start of every left slot. If the holding register is empty at that moment, the old pair is sent again and an underrun flag is raised.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted, bclk_o is 0, sdata_o is 0, underrun_o is 0, smp_ready_o is 1, and lrclk_o equals master_i.
- R2: With master_i = 1, each bclk_o level lasts div_i+1 system clock cycles, and sdata_o changes only in the cycle where bclk_o falls.
- R3: With master_i = 1, lrclk_o changes only where bclk_o falls. Each level of lrclk_o lasts SLOT_W bit clocks, with 0 marking the left slot and 1 the right slot.
- R4: fmt_i = 2'b01 (left-justified), and the reserved code 2'b11, put sample bit width_i-1 in the first bit period of the slot, then the lower bits in descending order. All later positions are 0.
- R5: fmt_i = 2'b00 (standard) sends the left-justified stream delayed by one bit period. The MSB is in the second bit period of the slot, and the last bit of one slot spills into the first bit period of the next slot.
- R6: fmt_i = 2'b10 (right-justified) puts sample bit 0 in the last bit period of the slot and the MSB width_i bit periods before the slot end. Earlier positions are 0.
- R7: Only the low width_i bits (1 to SMP_MAX) of each sample are sent. Sample bits at or above width_i never appear on sdata_o.
- R8: smp_ready_o is 1 exactly when the holding register is empty. A pair is taken when smp_valid_i and smp_ready_o are both 1, and smp_ready_o is 0 in the following cycle. The holding register empties at the start of each left slot.
- R9: At the start of a left slot with an empty holding register, the previous pair is sent again and underrun_o becomes 1. underrun_o returns to 0 at the next left-slot start that finds a pair waiting.
- R10: With master_i = 0, bclk_o and lrclk_o stay 0. sdata_o follows bclk_i and lrclk_i: it changes after each bclk_i falling edge, and slots begin at the lrclk_i transitions, with the same placements as R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate link clocks, 0: follow external clocks |
| fmt_i | input | 2 | Placement: 00 standard, 01 left, 10 right, 11 left |
| width_i | input | WID_W | Sample width in bits, 1 to SMP_MAX |
| div_i | input | DIV_W | Bit-clock half period minus one, in system clocks |
| bclk_i | input | 1 | External bit clock (follower mode) |
| lrclk_i | input | 1 | External left/right clock (follower mode) |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Holding register empty |
| smp_left_i | input | SMP_MAX | Left sample, right-aligned |
| smp_right_i | input | SMP_MAX | Right sample, right-aligned |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated left/right clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Last left-slot start repeated the old pair |

## Verification
As clock owner, the block registers the bit-clock toggle and the new data bit on the same system clock edge, so sdata_o, lrclk_o and underrun_o settle together with the falling bclk_o. The bench samples them at the next rising bclk_o, which comes div_i+1 cycles later, and checks bclk_o level lengths at every edge. As follower, two synchroniser stages and an edge detector put the new bit on sdata_o about three system cycles after bclk_i falls. The bench drives a bit clock with eight-cycle half periods and samples at its own rising edges, well after that delay. The expected bit at each slot position, and the expected underrun at each left-slot start, come from bench functions fed by the pairs the bench itself handed over.

// File: rtl/aud_ser_tx_pkg.sv
package aud_ser_tx_pkg;
  typedef enum logic [1:0] {
    FMT_STD = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_ser_tx_clkgen.sv
// Bit-clock strobe source: divider as clock owner, synchroniser as follower.
module aud_ser_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  output logic             fall_o,
  output logic             rise_o,
  output logic             bclk_o,
  output logic             lr_sync_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic [1:0]       bsync_q, lsync_q;
  logic             bprev_q;
  logic             half_done;
  logic             m_fall, m_rise, s_fall, s_rise;

  assign half_done = (cnt_q == div_i);

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!master_i) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (half_done) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      bsync_q <= 2'b00;
      lsync_q <= 2'b00;
      bprev_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      bclk_q  <= bclk_d;
      bsync_q <= {bsync_q[0], bclk_i};
      lsync_q <= {lsync_q[0], lrclk_i};
      bprev_q <= bsync_q[1];
    end
  end

  assign m_fall    = master_i && half_done && bclk_q;
  assign m_rise    = master_i && half_done && !bclk_q;
  assign s_fall    = !master_i && bprev_q && !bsync_q[1];
  assign s_rise    = !master_i && !bprev_q && bsync_q[1];
  assign fall_o    = m_fall || s_fall;
  assign rise_o    = m_rise || s_rise;
  assign bclk_o    = bclk_q;
  assign lr_sync_o = lsync_q[1];
endmodule

// File: rtl/aud_ser_tx_slot.sv
// Slot position and channel tracker; realigns to external LR edges as follower.
module aud_ser_tx_slot #(
  parameter int SLOT_W = 32,
  localparam int POS_W = $clog2(SLOT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             lr_i,
  output logic [POS_W-1:0] pos_nx_o,
  output logic             ch_nx_o,
  output logic             ch_o,
  output logic             frame_start_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOT_W - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             ch_q, ch_d;
  logic             seen_q, seen_d;
  logic             wrap;

  assign wrap     = (pos_q == LAST);
  assign pos_nx_o = wrap ? '0 : pos_q + 1'b1;
  assign ch_nx_o  = wrap ? ~ch_q : ch_q;

  always_comb begin
    pos_d  = pos_q;
    ch_d   = ch_q;
    seen_d = seen_q;
    if (fall_i) begin
      pos_d = pos_nx_o;
      ch_d  = ch_nx_o;
    end else if (rise_i && !master_i) begin
      seen_d = lr_i;
      if (lr_i != seen_q) begin
        pos_d = '0;
        ch_d  = lr_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST;
      ch_q   <= 1'b1;
      seen_q <= 1'b1;
    end else begin
      pos_q  <= pos_d;
      ch_q   <= ch_d;
      seen_q <= seen_d;
    end
  end

  assign ch_o          = ch_q;
  assign frame_start_o = fall_i && wrap && ch_q;
endmodule

// File: rtl/aud_ser_tx_hold.sv
// One-pair holding register in front of the active pair.
module aud_ser_tx_hold #(
  parameter int SMP_MAX = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [SMP_MAX-1:0] left_i,
  input  logic [SMP_MAX-1:0] right_i,
  input  logic               load_i,
  output logic               ready_o,
  output logic [SMP_MAX-1:0] use_l_o,
  output logic [SMP_MAX-1:0] use_r_o,
  output logic               underrun_o
);
  logic [SMP_MAX-1:0] pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic [SMP_MAX-1:0] act_l_q, act_r_q, act_l_d, act_r_d;
  logic               pend_v_q, pend_v_d;
  logic               und_q, und_d;
  logic               take, swap;

  assign ready_o = !pend_v_q;
  assign take    = valid_i && !pend_v_q;
  assign swap    = load_i && pend_v_q;

  always_comb begin
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    pend_v_d = pend_v_q;
    act_l_d  = act_l_q;
    act_r_d  = act_r_q;
    und_d    = und_q;
    if (take) begin
      pend_l_d = left_i;
      pend_r_d = right_i;
      pend_v_d = 1'b1;
    end
    if (load_i) begin
      und_d = !pend_v_q;
    end
    if (swap) begin
      act_l_d  = pend_l_q;
      act_r_d  = pend_r_q;
      pend_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      pend_v_q <= 1'b0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      und_q    <= 1'b0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      pend_v_q <= pend_v_d;
      act_l_q  <= act_l_d;
      act_r_q  <= act_r_d;
      und_q    <= und_d;
    end
  end

  assign use_l_o    = swap ? pend_l_q : act_l_q;
  assign use_r_o    = swap ? pend_r_q : act_r_q;
  assign underrun_o = und_q;
endmodule

// File: rtl/aud_ser_tx_bitsel.sv
// Picks the sample bit for a slot position, left- and right-aligned.
module aud_ser_tx_bitsel #(
  parameter int SLOT_W  = 32,
  parameter int SMP_MAX = 24,
  localparam int POS_W  = $clog2(SLOT_W),
  localparam int WID_W  = $clog2(SMP_MAX + 1),
  localparam int CW     = POS_W + 2
) (
  input  logic [WID_W-1:0]   width_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic [SMP_MAX-1:0] sample_i,
  output logic               lj_o,
  output logic               rj_o
);
  logic [CW-1:0] w, p, lj_idx, rj_idx;

  assign w      = CW'(width_i);
  assign p      = CW'(pos_i);
  assign lj_idx = w - CW'(1) - p;
  assign rj_idx = CW'(SLOT_W - 1) - p;

  always_comb begin
    lj_o = 1'b0;
    rj_o = 1'b0;
    for (int b = 0; b < SMP_MAX; b++) begin
      if (CW'(b) < w) begin
        if (CW'(b) == lj_idx) lj_o = sample_i[b];
        if (CW'(b) == rj_idx) rj_o = sample_i[b];
      end
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_tx_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SMP_MAX  = 24,
  parameter int DIV_W    = 8,
  localparam int POS_W   = $clog2(SLOT_W),
  localparam int WID_W   = $clog2(SMP_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_i,
  input  logic [1:0]         fmt_i,
  input  logic [WID_W-1:0]   width_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               bclk_i,
  input  logic               lrclk_i,
  input  logic               smp_valid_i,
  output logic               smp_ready_o,
  input  logic [SMP_MAX-1:0] smp_left_i,
  input  logic [SMP_MAX-1:0] smp_right_i,
  output logic               bclk_o,
  output logic               lrclk_o,
  output logic               sdata_o,
  output logic               underrun_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               fall_stb, rise_stb, bclk_gen, lr_sync;
  logic [POS_W-1:0]   pos_nx;
  logic               ch_nx, ch_cur, frame_start;
  logic [SMP_MAX-1:0] use_l, use_r, cur_smp;
  logic               lj_bit, rj_bit;
  logic               sdata_q, sdata_d, dly_q, dly_d;
  fmt_e               fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  aud_ser_tx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n_int), .master_i(master_i), .div_i(div_i),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i), .fall_o(fall_stb), .rise_o(rise_stb),
    .bclk_o(bclk_gen), .lr_sync_o(lr_sync)
  );

  aud_ser_tx_slot #(.SLOT_W(SLOT_W)) slot_i (
    .clk(clk), .rst_n(rst_n_int), .master_i(master_i), .fall_i(fall_stb),
    .rise_i(rise_stb), .lr_i(lr_sync), .pos_nx_o(pos_nx), .ch_nx_o(ch_nx),
    .ch_o(ch_cur), .frame_start_o(frame_start)
  );

  aud_ser_tx_hold #(.SMP_MAX(SMP_MAX)) hold_i (
    .clk(clk), .rst_n(rst_n_int), .valid_i(smp_valid_i), .left_i(smp_left_i),
    .right_i(smp_right_i), .load_i(frame_start), .ready_o(smp_ready_o),
    .use_l_o(use_l), .use_r_o(use_r), .underrun_o(underrun_o)
  );

  assign cur_smp = ch_nx ? use_r : use_l;

  aud_ser_tx_bitsel #(.SLOT_W(SLOT_W), .SMP_MAX(SMP_MAX)) bitsel_i (
    .width_i(width_i), .pos_i(pos_nx), .sample_i(cur_smp),
    .lj_o(lj_bit), .rj_o(rj_bit)
  );

  assign fmt = fmt_e'(fmt_i);

  always_comb begin
    sdata_d = sdata_q;
    dly_d   = dly_q;
    if (fall_stb) begin
      dly_d = lj_bit;
      case (fmt)
        FMT_STD: sdata_d = dly_q;
        FMT_RJ:  sdata_d = rj_bit;
        default: sdata_d = lj_bit;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sdata_q <= 1'b0;
      dly_q   <= 1'b0;
    end else begin
      sdata_q <= sdata_d;
      dly_q   <= dly_d;
    end
  end

  assign sdata_o = sdata_q;
  assign bclk_o  = master_i && bclk_gen;
  assign lrclk_o = master_i && ch_cur;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic master_i,
  input logic smp_valid_i,
  input logic smp_ready_o,
  input logic bclk_o,
  input logic lrclk_o,
  input logic sdata_o,
  input logic underrun_o
);
  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |-> (!bclk_o && !lrclk_o));

  assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && !$stable(sdata_o)) |-> $fell(bclk_o));

  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && !$stable(lrclk_o)) |-> $fell(bclk_o));

  assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

  assert_under_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && !$stable(underrun_o)) |-> $fell(bclk_o));
endmodule

bind aud_ser_tx aud_ser_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .master_i(master_i), .smp_valid_i(smp_valid_i),
  .smp_ready_o(smp_ready_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
  .sdata_o(sdata_o), .underrun_o(underrun_o)
);

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  localparam int SW = 16;
  localparam int SM = 16;
  localparam int DW = 8;
  localparam int WW = $clog2(SM + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, master_i, bclk_i, lrclk_i, smp_valid_i;
  logic [1:0]    fmt_i;
  logic [WW-1:0] width_i;
  logic [DW-1:0] div_i;
  logic [SM-1:0] smp_left_i, smp_right_i;
  logic          smp_ready_o, bclk_o, lrclk_o, sdata_o, underrun_o;

  aud_ser_tx #(.SLOT_W(SW), .SMP_MAX(SM), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_i(master_i), .fmt_i(fmt_i),
    .width_i(width_i), .div_i(div_i), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .smp_left_i(smp_left_i), .smp_right_i(smp_right_i), .bclk_o(bclk_o),
    .lrclk_o(lrclk_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [SM-1:0] act_l, act_r, bp_l, bp_r;
  bit bpv, prev_lj, drop;
  int frame;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit lj_f(logic [SM-1:0] s, int w, int p);
    if (p < w) return s[w-1-p];
    return 1'b0;
  endfunction

  function automatic bit rj_f(logic [SM-1:0] s, int w, int p);
    int idx = SW - 1 - p;
    if (idx < w) return s[idx];
    return 1'b0;
  endfunction

  // Checks one received bit against the bench model; feeds a pair at left pos 4.
  task automatic model_bit(int fm, int w, bit ch, int pos, bit d, bit u,
                           string req, int skip);
    logic [SM-1:0] s;
    bit lj, e;
    if (!ch && pos == 0) begin
      bit eu;
      frame++;
      eu = !bpv;
      if (bpv) begin
        act_l = bp_l; act_r = bp_r; bpv = 1'b0;
      end
      chk(u == eu, "R9", "underrun at left slot start", u, eu);
    end
    s  = ch ? act_r : act_l;
    lj = lj_f(s, w, pos);
    if (fm == 0)      e = prev_lj;
    else if (fm == 2) e = rj_f(s, w, pos);
    else              e = lj;
    prev_lj = lj;
    chk(d == e, req, $sformatf("data ch=%0d pos=%0d frame=%0d", ch, pos, frame), d, e);
    if (!ch && pos == 4 && frame != skip) begin
      chk(smp_ready_o == 1'b1, "R8", "ready with empty holding register", smp_ready_o, 1);
      smp_left_i  = SM'($urandom);
      smp_right_i = SM'($urandom);
      smp_valid_i = 1'b1;
      bp_l = smp_left_i; bp_r = smp_right_i; bpv = 1'b1;
      drop = 1'b1;
    end
  endtask

  task automatic run_phase(bit m, int fm, int w, int dv, int nfr, int skip);
    string req;
    if (m) req = (fm == 0) ? "R5" : (fm == 2) ? "R6" : "R4";
    else   req = "R10";
    if (w < SM) req = {req, ",R7"};
    rst_n = 1'b0; master_i = m; fmt_i = 2'(fm); width_i = WW'(w);
    div_i = DW'(dv); bclk_i = 1'b1; lrclk_i = 1'b1; smp_valid_i = 1'b0;
    smp_left_i = '0; smp_right_i = '0;
    act_l = '0; act_r = '0; bpv = 1'b0; prev_lj = 1'b0; frame = 0; drop = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bclk_o == 1'b0, "R1", "bclk_o in reset", bclk_o, 0);
    chk(lrclk_o == m, "R1", "lrclk_o in reset", lrclk_o, m);
    chk(sdata_o == 1'b0, "R1", "sdata_o in reset", sdata_o, 0);
    chk(smp_ready_o == 1'b1, "R1", "smp_ready_o in reset", smp_ready_o, 1);
    chk(underrun_o == 1'b0, "R1", "underrun_o in reset", underrun_o, 0);
    rst_n = 1'b1;
    if (m) begin
      bit pb = 1'b0, pl = 1'b1, seen = 1'b0;
      int hcnt = 0, nedge = 0, pos = 0;
      while (frame <= nfr) begin
        @(negedge clk);
        if (drop) begin smp_valid_i = 1'b0; drop = 1'b0; end
        hcnt++;
        if (bclk_o != pb) begin
          if (nedge > 0) chk(hcnt == dv + 1, "R2", "bclk half period", hcnt, dv + 1);
          nedge++;
          hcnt = 0;
          pb = bclk_o;
          if (bclk_o) begin
            if (lrclk_o != pl) begin
              if (seen) chk(pos + 1 == SW, "R3", "slot length", pos + 1, SW);
              seen = 1'b1;
              pos = 0;
            end else begin
              pos++;
            end
            pl = lrclk_o;
            if (seen) model_bit(fm, w, lrclk_o, pos, sdata_o, underrun_o, req, skip);
          end
        end
      end
    end else begin
      bit sb = 1'b1, sch = 1'b1, seen = 1'b0;
      int sc = 0, spos = SW - 1;
      repeat (4) @(negedge clk);
      while (frame <= nfr) begin
        @(negedge clk);
        if (drop) begin smp_valid_i = 1'b0; drop = 1'b0; end
        sc++;
        if (sc == 8) begin
          sc = 0;
          sb = ~sb;
          if (!sb) begin
            if (spos == SW - 1) begin spos = 0; sch = ~sch; end
            else spos++;
            seen = 1'b1;
          end else if (seen) begin
            chk(bclk_o == 1'b0 && lrclk_o == 1'b0, "R10", "clock outputs quiet",
                int'({bclk_o, lrclk_o}), 0);
            model_bit(fm, w, sch, spos, sdata_o, underrun_o, req, skip);
          end
          bclk_i = sb;
          lrclk_i = sch;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    run_phase(1'b1, 0, SM, 1, 4, 99);  // R5 spill of full-width LSB
    run_phase(1'b1, 1, 1, 2, 3, 99);   // R4 width 1
    run_phase(1'b1, 2, SM, 1, 3, 99);  // R6 full width
    run_phase(1'b1, 2, 5, 3, 3, 99);   // R6 narrow, R7
    run_phase(1'b1, 3, 7, 1, 3, 99);   // R4 reserved code
    run_phase(1'b1, 1, 12, 1, 5, 2);   // R9 repeat after missed feed
    run_phase(1'b0, 0, 12, 1, 3, 99);  // R10 standard
    run_phase(1'b0, 2, 9, 1, 3, 1);    // R10 right-justified with underrun
    for (int i = 0; i < 6; i++) begin
      run_phase(1'($urandom_range(0, 1)), $urandom_range(0, 3),
                $urandom_range(1, SM), $urandom_range(1, 3), 3,
                $urandom_range(1, 3));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule